// File: doc/BRIEF.md
# Banked Accumulator and Index Register File

This block is the register file of a 16-bit processor datapath. It holds two byte accumulators that can also be reached together as one 16-bit double accumulator, a separate 16-bit accumulator, and three 16-bit index registers. Each index register has its own 4-bit extension field. Joined together, an extension field and its index register give a 20-bit pointer.

Writes arrive on several synchronous write ports. Each port carries an enable, a register code and 16 bits of data, and the register code also fixes the width of the write. The two read ports are combinational. An effective-address output adds an offset to a selected 20-bit pointer and wraps modulo 2^20. The offset can be an 8-bit or 16-bit displacement, or the separate accumulator.

During reset the third index register and its extension field load from reset-vector inputs, so that pair points at a direct page as soon as reset ends. Every other register clears.

Top module: `regbank_top`

## Requirements
- R1: While rst_n is low, IZ takes rst_iz_vec and ZK takes rst_zk_vec. A, B, E, IX, IY, XK and YK all clear to zero.
- R2: Register codes are A=0, B=1, D=2, E=3, IX=4, IY=5, IZ=6, XK=8, YK=9 and ZK=10. A write changes the register at the next rising clock edge. A byte register keeps wr_data bits 7:0, and an extension field keeps bits 3:0. Narrow registers read back zero-extended to 16 bits. A register that no port writes keeps its value.
- R3: D reads as {A, B}, with A as the high byte. A write to D puts bits 15:8 into A and bits 7:0 into B.
- R4: When one port writes D and another port writes A or B in the same cycle, the byte write wins for its own byte, whatever the port numbers are. The other byte takes its half of the D data.
- R5: When two ports write the same register in the same cycle, and the R4 case does not apply, the port with the higher index wins.
- R6: The read ports are combinational and show the value held before the coming clock edge. Codes 7 and 11 to 15 read as zero, and a write to one of those codes changes no register.
- R7: With ea_mode 0, ea_addr is the base pointer plus ea_off[7:0], sign-extended.
- R8: With ea_mode 1, ea_addr is the base pointer plus ea_off[15:0], sign-extended.
- R9: With ea_mode 2, ea_addr is the base pointer plus accumulator E, taken as a signed value. With ea_mode 3 the offset is zero.
- R10: The sum is taken modulo 2^20, so a carry or a borrow out of the index register changes the extension field bits of the result.
- R11: ea_base picks the base pointer: 0 for XK:IX, 1 for YK:IY, 2 for ZK:IZ, and 3 for a base of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_iz_vec | input | 16 | Reset value for IZ |
| rst_zk_vec | input | 4 | Reset value for ZK |
| wr_en | input | 2 | Enable for each write port |
| wr_code | input | 2x4 | Register code for each write port |
| wr_data | input | 2x16 | Data for each write port |
| rd_code | input | 2x4 | Register code for each read port |
| rd_data | output | 2x16 | Data for each read port, zero-extended |
| ea_base | input | 2 | Selects the base pointer |
| ea_mode | input | 2 | Selects the offset source |
| ea_off | input | 16 | Displacement input |
| ea_addr | output | 20 | Effective address |

## Verification
Directed writes cover four cases:
- A lone D write shows that the bytes land in the right order.
- A D write paired with a byte write, with the ports swapped on a second run, shows that the byte write beats D and that port order does not decide it.
- Two ports writing E show that the higher port index wins.
- Writes to unused codes show that such writes change nothing.

Address tests set pointers near 0xFFFF and 0x0000 and apply offsets of both signs, which tells a correct 20-bit wrap apart from a 16-bit wrap or a missing sign extension. Each offset mode and each base select is tried in turn. A long run of random writes, reads and address requests is then compared every cycle against a behavioural model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int EXT_W  = 4;
    localparam int CODE_W = 4;
    localparam int ADDR_W = DATA_W + EXT_W;
    localparam int NUM_IDX = 3;

    typedef enum logic [CODE_W-1:0] {
        RC_A  = 4'd0,
        RC_B  = 4'd1,
        RC_D  = 4'd2,
        RC_E  = 4'd3,
        RC_IX = 4'd4,
        RC_IY = 4'd5,
        RC_IZ = 4'd6,
        RC_XK = 4'd8,
        RC_YK = 4'd9,
        RC_ZK = 4'd10
    } reg_code_e;

    typedef enum logic [1:0] {
        EA_OFF8  = 2'd0,
        EA_OFF16 = 2'd1,
        EA_ACCE  = 2'd2,
        EA_NONE  = 2'd3
    } ea_mode_e;

    typedef enum logic [1:0] {
        BASE_X   = 2'd0,
        BASE_Y   = 2'd1,
        BASE_Z   = 2'd2,
        BASE_ABS = 2'd3
    } ea_base_e;
endpackage

// File: rtl/regbank_acc.sv
module regbank_acc
    import regbank_pkg::*;
#(
    parameter int NUM_WR = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_WR-1:0]                  wr_en,
    input  logic [NUM_WR-1:0][CODE_W-1:0]      wr_code,
    input  logic [NUM_WR-1:0][DATA_W-1:0]      wr_data,
    output logic [BYTE_W-1:0]                  a_q,
    output logic [BYTE_W-1:0]                  b_q,
    output logic [DATA_W-1:0]                  e_q
);
    logic [BYTE_W-1:0] a_n, b_n;
    logic [DATA_W-1:0] e_n;

    // Double writes are applied first so byte writes override them.
    always_comb begin
        a_n = a_q;
        b_n = b_q;
        e_n = e_q;
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p] && wr_code[p] == RC_D) begin
                a_n = wr_data[p][DATA_W-1:BYTE_W];
                b_n = wr_data[p][BYTE_W-1:0];
            end
        end
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p]) begin
                if (wr_code[p] == RC_A) a_n = wr_data[p][BYTE_W-1:0];
                if (wr_code[p] == RC_B) b_n = wr_data[p][BYTE_W-1:0];
                if (wr_code[p] == RC_E) e_n = wr_data[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            e_q <= '0;
        end else begin
            a_q <= a_n;
            b_q <= b_n;
            e_q <= e_n;
        end
    end
endmodule

// File: rtl/regbank_idx.sv
module regbank_idx
    import regbank_pkg::*;
#(
    parameter int                NUM_WR   = 2,
    parameter logic [CODE_W-1:0] IDX_CODE = RC_IX,
    parameter logic [CODE_W-1:0] EXT_CODE = RC_XK
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [DATA_W-1:0]                  rst_idx,
    input  logic [EXT_W-1:0]                   rst_ext,
    input  logic [NUM_WR-1:0]                  wr_en,
    input  logic [NUM_WR-1:0][CODE_W-1:0]      wr_code,
    input  logic [NUM_WR-1:0][DATA_W-1:0]      wr_data,
    output logic [DATA_W-1:0]                  idx_q,
    output logic [EXT_W-1:0]                   ext_q
);
    logic [DATA_W-1:0] idx_n;
    logic [EXT_W-1:0]  ext_n;

    always_comb begin
        idx_n = idx_q;
        ext_n = ext_q;
        for (int p = 0; p < NUM_WR; p++) begin
            if (wr_en[p] && wr_code[p] == IDX_CODE) idx_n = wr_data[p];
            if (wr_en[p] && wr_code[p] == EXT_CODE) ext_n = wr_data[p][EXT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= rst_idx;
            ext_q <= rst_ext;
        end else begin
            idx_q <= idx_n;
            ext_q <= ext_n;
        end
    end
endmodule

// File: rtl/regbank_ea.sv
module regbank_ea
    import regbank_pkg::*;
(
    input  logic [1:0]          base_sel,
    input  logic [1:0]          mode,
    input  logic [DATA_W-1:0]   off,
    input  logic [DATA_W-1:0]   e_val,
    input  logic [ADDR_W-1:0]   ptr_x,
    input  logic [ADDR_W-1:0]   ptr_y,
    input  logic [ADDR_W-1:0]   ptr_z,
    output logic [ADDR_W-1:0]   addr
);
    logic [ADDR_W-1:0] base, ofs;

    always_comb begin
        unique case (ea_base_e'(base_sel))
            BASE_X:   base = ptr_x;
            BASE_Y:   base = ptr_y;
            BASE_Z:   base = ptr_z;
            BASE_ABS: base = '0;
        endcase
        unique case (ea_mode_e'(mode))
            EA_OFF8:  ofs = {{(ADDR_W-BYTE_W){off[BYTE_W-1]}}, off[BYTE_W-1:0]};
            EA_OFF16: ofs = {{(ADDR_W-DATA_W){off[DATA_W-1]}}, off};
            EA_ACCE:  ofs = {{(ADDR_W-DATA_W){e_val[DATA_W-1]}}, e_val};
            EA_NONE:  ofs = '0;
        endcase
        addr = base + ofs;
    end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int NUM_WR = 2,
    parameter int NUM_RD = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [DATA_W-1:0]                  rst_iz_vec,
    input  logic [EXT_W-1:0]                   rst_zk_vec,
    input  logic [NUM_WR-1:0]                  wr_en,
    input  logic [NUM_WR-1:0][CODE_W-1:0]      wr_code,
    input  logic [NUM_WR-1:0][DATA_W-1:0]      wr_data,
    input  logic [NUM_RD-1:0][CODE_W-1:0]      rd_code,
    output logic [NUM_RD-1:0][DATA_W-1:0]      rd_data,
    input  logic [1:0]                         ea_base,
    input  logic [1:0]                         ea_mode,
    input  logic [DATA_W-1:0]                  ea_off,
    output logic [ADDR_W-1:0]                  ea_addr
);
    logic [BYTE_W-1:0] a_q, b_q;
    logic [DATA_W-1:0] e_q;
    logic [DATA_W-1:0] idx_q [NUM_IDX];
    logic [EXT_W-1:0]  ext_q [NUM_IDX];

    regbank_acc #(.NUM_WR(NUM_WR)) acc_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .a_q(a_q), .b_q(b_q), .e_q(e_q)
    );

    // Only the last index register takes its reset value from the vector.
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        localparam logic [CODE_W-1:0] ICODE = CODE_W'(int'(RC_IX) + g);
        localparam logic [CODE_W-1:0] KCODE = CODE_W'(int'(RC_XK) + g);
        logic [DATA_W-1:0] rv_idx;
        logic [EXT_W-1:0]  rv_ext;
        if (g == NUM_IDX - 1) begin : g_vec
            assign rv_idx = rst_iz_vec;
            assign rv_ext = rst_zk_vec;
        end else begin : g_zero
            assign rv_idx = '0;
            assign rv_ext = '0;
        end
        regbank_idx #(.NUM_WR(NUM_WR), .IDX_CODE(ICODE), .EXT_CODE(KCODE)) idx_i (
            .clk(clk), .rst_n(rst_n),
            .rst_idx(rv_idx), .rst_ext(rv_ext),
            .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
            .idx_q(idx_q[g]), .ext_q(ext_q[g])
        );
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        always_comb begin
            case (rd_code[r])
                RC_A:    rd_data[r] = {{(DATA_W-BYTE_W){1'b0}}, a_q};
                RC_B:    rd_data[r] = {{(DATA_W-BYTE_W){1'b0}}, b_q};
                RC_D:    rd_data[r] = {a_q, b_q};
                RC_E:    rd_data[r] = e_q;
                RC_IX:   rd_data[r] = idx_q[0];
                RC_IY:   rd_data[r] = idx_q[1];
                RC_IZ:   rd_data[r] = idx_q[2];
                RC_XK:   rd_data[r] = {{(DATA_W-EXT_W){1'b0}}, ext_q[0]};
                RC_YK:   rd_data[r] = {{(DATA_W-EXT_W){1'b0}}, ext_q[1]};
                RC_ZK:   rd_data[r] = {{(DATA_W-EXT_W){1'b0}}, ext_q[2]};
                default: rd_data[r] = '0;
            endcase
        end
    end

    regbank_ea ea_i (
        .base_sel(ea_base), .mode(ea_mode), .off(ea_off), .e_val(e_q),
        .ptr_x({ext_q[0], idx_q[0]}),
        .ptr_y({ext_q[1], idx_q[1]}),
        .ptr_z({ext_q[2], idx_q[2]}),
        .addr(ea_addr)
    );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [1:0]                  wr_en,
    input logic [1:0][CODE_W-1:0]      wr_code,
    input logic [1:0][DATA_W-1:0]      wr_data,
    input logic [CODE_W-1:0]           rd_code0,
    input logic [DATA_W-1:0]           rd_data0,
    input logic [BYTE_W-1:0]           a_q,
    input logic [BYTE_W-1:0]           b_q,
    input logic [DATA_W-1:0]           e_q
);
    // R3
    d_write_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 2'b01 && wr_code[0] == RC_D) |=>
        (a_q == $past(wr_data[0][15:8]) && b_q == $past(wr_data[0][7:0])));

    // R4
    byte_over_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 2'b11 && wr_code[0] == RC_D && wr_code[1] == RC_A) |=>
        (a_q == $past(wr_data[1][7:0]) && b_q == $past(wr_data[0][7:0])));

    // R5
    late_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 2'b11 && wr_code[0] == RC_E && wr_code[1] == RC_E) |=>
        (e_q == $past(wr_data[1])));

    // R6
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code0 == 4'd7 || rd_code0 > 4'd10) |-> (rd_data0 == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == 2'b00) |=> ($stable(e_q) && $stable(a_q) && $stable(b_q)));
endmodule

bind regbank_top regbank_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
    .rd_code0(rd_code[0]), .rd_data0(rd_data[0]),
    .a_q(a_q), .b_q(b_q), .e_q(e_q)
);

// File: tb/regbank_top_tb_top.sv
module regbank_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] rst_iz_vec = 16'h1234;
    logic [3:0]  rst_zk_vec = 4'h5;
    logic [1:0]        wr_en = '0;
    logic [1:0][3:0]   wr_code = '0;
    logic [1:0][15:0]  wr_data = '0;
    logic [1:0][3:0]   rd_code = '0;
    logic [1:0][15:0]  rd_data;
    logic [1:0]        ea_base = '0;
    logic [1:0]        ea_mode = '0;
    logic [15:0]       ea_off = '0;
    logic [19:0]       ea_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_a, m_b, m_e;
    int m_i [3];
    int m_k [3];

    always #5 clk = ~clk;

    regbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .rst_iz_vec(rst_iz_vec), .rst_zk_vec(rst_zk_vec),
        .wr_en(wr_en), .wr_code(wr_code), .wr_data(wr_data),
        .rd_code(rd_code), .rd_data(rd_data),
        .ea_base(ea_base), .ea_mode(ea_mode), .ea_off(ea_off), .ea_addr(ea_addr)
    );

    function automatic int model_rd(int code);
        case (code)
            0: return m_a;
            1: return m_b;
            2: return m_a * 256 + m_b;
            3: return m_e;
            4, 5, 6: return m_i[code-4];
            8, 9, 10: return m_k[code-8];
            default: return 0;
        endcase
    endfunction

    function automatic int sx(int v, int bits);
        int m = 1 << bits;
        v = v % m;
        if (v >= m / 2) v -= m;
        return v;
    endfunction

    function automatic int model_ea();
        int base, o;
        base = (ea_base == 2'd3) ? 0 : m_k[ea_base] * 65536 + m_i[ea_base];
        case (ea_mode)
            2'd0: o = sx(int'(ea_off[7:0]), 8);
            2'd1: o = sx(int'(ea_off), 16);
            2'd2: o = sx(m_e, 16);
            default: o = 0;
        endcase
        return (base + o) & 32'hFFFFF;
    endfunction

    function automatic void model_write(int code, int d);
        case (code)
            0: m_a = d & 255;
            1: m_b = d & 255;
            3: m_e = d;
            4, 5, 6: m_i[code-4] = d;
            8, 9, 10: m_k[code-8] = d & 15;
            default: ;
        endcase
    endfunction

    function automatic void model_commit();
        for (int p = 0; p < 2; p++)
            if (wr_en[p] && wr_code[p] == 4'd2) begin
                m_a = int'(wr_data[p][15:8]);
                m_b = int'(wr_data[p][7:0]);
            end
        for (int p = 0; p < 2; p++)
            if (wr_en[p] && wr_code[p] != 4'd2) model_write(int'(wr_code[p]), int'(wr_data[p]));
    endfunction

    function automatic string rd_tag(int code);
        if (code <= 2) return "R3";
        if (code == 7 || code > 10) return "R6";
        return "R2";
    endfunction

    function automatic string ea_tag();
        case (ea_mode)
            2'd0: return "R7";
            2'd1: return "R8";
            2'd2: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives the current inputs, compares outputs, then clocks once.
    task automatic cyc(string rtag = "", string etag = "");
        #1;
        for (int r = 0; r < 2; r++)
            check(rtag != "" ? rtag : rd_tag(int'(rd_code[r])),
                  int'(rd_data[r]), model_rd(int'(rd_code[r])));
        check(etag != "" ? etag : ea_tag(), int'(ea_addr), model_ea());
        @(posedge clk);
        model_commit();
        @(negedge clk);
        wr_en = '0;
    endtask

    task automatic wr(int p, int code, int data);
        wr_en[p] = 1'b1;
        wr_code[p] = 4'(code);
        wr_data[p] = 16'(data);
    endtask

    task automatic rd(int c0, int c1);
        rd_code[0] = 4'(c0);
        rd_code[1] = 4'(c1);
    endtask

    task automatic ea(int b, int m, int o);
        ea_base = 2'(b);
        ea_mode = 2'(m);
        ea_off = 16'(o);
    endtask

    initial begin
        m_a = 0; m_b = 0; m_e = 0;
        m_i[0] = 0; m_i[1] = 0; m_i[2] = 'h1234;
        m_k[0] = 0; m_k[1] = 0; m_k[2] = 5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents, IZ/ZK from the vector
        rd(6, 10); ea(2, 3, 0); cyc("R1", "R1");
        rd(2, 3);  ea(0, 3, 0); cyc("R1", "R1");
        rd(4, 9);  ea(1, 3, 0); cyc("R1", "R1");

        // R3: D write splits into A (high) and B (low)
        wr(0, 2, 'hA5C3); rd(0, 1); cyc();
        rd(0, 1); cyc("R3");
        rd(2, 2); cyc("R3");

        // R4: byte write beats D, both port orders
        wr(0, 2, 'h1111); wr(1, 0, 'h0022); cyc();
        rd(2, 0); cyc("R4");
        wr(0, 1, 'h0077); wr(1, 2, 'h8899); cyc();
        rd(2, 1); cyc("R4");

        // R5: higher port wins on E
        wr(0, 3, 'h0001); wr(1, 3, 'h0002); cyc();
        rd(3, 3); cyc("R5");

        // R2: byte write keeps low bits, extension keeps low nibble
        wr(0, 0, 'hABCD); wr(1, 9, 'hFFF3); cyc();
        rd(0, 9); cyc("R2");

        // R6: unused codes change nothing and read zero
        wr(0, 7, 'hDEAD); wr(1, 15, 'hBEEF); rd(7, 12); cyc("R6");
        rd(2, 3); cyc("R6");
        rd(0, 1); cyc("R6");

        // R10: carry into extension, borrow out of it
        wr(0, 8, 'hF); wr(1, 4, 'hFFF0); cyc();
        rd(4, 8); ea(0, 0, 'h0020); cyc("", "R10");
        wr(0, 8, 1); wr(1, 4, 0); cyc();
        ea(0, 0, 'h00FF); cyc("", "R10");
        ea(0, 1, 'h8000); cyc("", "R8");

        // R7, R8, R9, R11 on other bases
        wr(0, 5, 'h4000); wr(1, 3, 'hFFFE); cyc();
        ea(1, 0, 'h007F); cyc("", "R7");
        ea(1, 1, 'h7FFF); cyc("", "R8");
        ea(1, 2, 0); cyc("", "R9");
        ea(3, 1, 'h1234); cyc("", "R11");
        ea(2, 2, 0); cyc("", "R11");

        // Random run compared every clock against the model
        for (int n = 0; n < 1500; n++) begin
            for (int p = 0; p < 2; p++)
                if ($urandom_range(0, 1) == 1) wr(p, $urandom_range(0, 15), $urandom_range(0, 65535));
            rd($urandom_range(0, 15), $urandom_range(0, 15));
            ea($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 65535));
            cyc();
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule